// File: doc/BRIEF.md
# Host Register Bank with Configuration Controls

This block is an 8-bit register bank placed between a microprocessor bus and the control logic of a programmable device. The host reaches it with single-cycle write and read strobes, a 5-bit address and a data byte. Reads are registered, so the requested byte appears on the read data output one clock edge after the read strobe. The lower half of the address space (00h–0Fh) holds the block's own registers. The upper half (10h–1Fh) is handed to user logic through a select, strobes, a 4-bit offset and the write byte. The byte returned from user logic is captured into the same read register.

The first control register drives three device-wide levels. The global set/reset output is active high. The readback request and the program request are both active low. Each of these levels stays where the host last put it until the host writes it back. When the host moves the readback bit from 1 to 0 while configuration is complete, the block also emits a one-cycle readback start pulse. The bank also provides a second control byte, a scratchpad, a status input window, a configuration data port, a 16-bit readback address and a read-only 32-bit device identifier taken from a parameter.

Top module: `hostRegBank`

## Requirements
- R1: After reset, rdData is 00h, gsrOut is 0, progN is 1, rbReqN is 1, rbStart is 0, ctrl2Out is 00h and rbAddr is 0000h.
- R2: Control register 1 at address 00h is read/write. Only bits 7, 5 and 0 are stored. Bits 6 and 4–1 read as 0 whatever is written, so writing FFh reads back A1h.
- R3: gsrOut equals control 1 bit 0. It stays asserted until the host writes 0 to that bit, and its reset value is 0.
- R4: rbReqN equals control 1 bit 5, with reset value 1. rbStart is high for exactly the one cycle after a write to 00h that changes bit 5 from 1 to 0 while cfgDone is high. No other write produces it.
- R5: progN equals control 1 bit 7, with reset value 1. Driving progN or gsrOut active does not alter any register at 00h–0Fh.
- R6: Addresses 01h (control 2, shown on ctrl2Out), 02h (scratchpad), 05h (readback address low) and 06h (readback address high) are read/write. rbAddr is {06h, 05h}.
- R7: A read of 03h returns statusIn and a read of 04h returns dataIn. A write to 04h raises dataWrStb in that cycle, with dataWrByte equal to the written byte.
- R8: Addresses 07h to 0Ah return the device identifier parameter, least significant byte at 07h. Writes to these addresses are ignored.
- R9: Addresses 0Bh–0Fh read as 00h, and writes to them change nothing.
- R10: While wrEn or rdEn is high with address bit 4 set, userSel is high, userAddr is address bits 3:0, userWe equals wrEn and userRe equals rdEn. A read there returns userRdData. Otherwise userSel, userWe and userRe are low.
- R11: rdData is loaded on the clock edge at which rdEn is high and holds its value in every other cycle. A read in the same cycle as a write returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | 5 | Register address |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Registered read byte |
| statusIn | input | 8 | Device status byte, readable at 03h |
| dataIn | input | 8 | Configuration/readback data byte, readable at 04h |
| cfgDone | input | 1 | Configuration has completed |
| dataWrStb | output | 1 | Write to the data port in this cycle |
| dataWrByte | output | 8 | Byte written to the data port |
| gsrOut | output | 1 | Global set/reset, active high |
| rbReqN | output | 1 | Readback request level, active low |
| rbStart | output | 1 | One-cycle readback start pulse |
| progN | output | 1 | Program request level, active low |
| ctrl2Out | output | 8 | Control register 2 contents |
| rbAddr | output | 16 | Readback address |
| userSel | output | 1 | Access to user address space |
| userWe | output | 1 | User-space write strobe |
| userRe | output | 1 | User-space read strobe |
| userAddr | output | 4 | Offset within user space |
| userWrData | output | 8 | Write byte for user logic |
| userRdData | input | 8 | Read byte from user logic |

## Verification
The assertions assume that userRdData, statusIn and dataIn are stable around the clock edge of a read. They also assume that cfgDone is sampled at the edge of the control-register write. The readback-pulse property relates the pulse to the bus write and to cfgDone one cycle earlier, so it needs those inputs to be sampled values rather than glitches. The stimulus drives every input only at the falling clock edge. It never asserts wrEn and rdEn together toward the user space, and it toggles cfgDone only in idle cycles between writes. Each readback-start case is therefore attributable to a single write.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
  localparam int DATA_W  = 8;
  localparam int ID_W    = 32;
  localparam int ID_BYTES = ID_W / DATA_W;

  // control register 1 bit positions (decoded by neighbouring logic)
  localparam int GSR_BIT = 0;
  localparam int RB_BIT  = 5;
  localparam int PRG_BIT = 7;

  // local register offsets
  localparam logic [3:0] OFS_CTRL1   = 4'h0;
  localparam logic [3:0] OFS_CTRL2   = 4'h1;
  localparam logic [3:0] OFS_SCRATCH = 4'h2;
  localparam logic [3:0] OFS_STATUS  = 4'h3;
  localparam logic [3:0] OFS_DATA    = 4'h4;
  localparam logic [3:0] OFS_RBLO    = 4'h5;
  localparam logic [3:0] OFS_RBHI    = 4'h6;
  localparam logic [3:0] OFS_ID0     = 4'h7;
  localparam logic [3:0] OFS_ID3     = 4'hA;

  typedef struct packed {
    logic ctrl1We;
    logic ctrl2We;
    logic scratchWe;
    logic rbLoWe;
    logic rbHiWe;
    logic rdLoad;
  } regStrobes_t;
endpackage

// File: rtl/hostRegCtrl.sv
module hostRegCtrl
  import hostreg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rbBitNew,
  input  logic              rbBitNow,
  input  logic              cfgDone,
  output regStrobes_t       strb,
  output logic              rbStart,
  output logic              dataWrStb,
  output logic              userSel,
  output logic              userWe,
  output logic              userRe
);
  localparam int OFS_W = ADDR_W - 1;

  logic             inUser;
  logic [OFS_W-1:0] ofs;
  logic             localWr;

  assign inUser  = addr[ADDR_W-1];
  assign ofs     = addr[OFS_W-1:0];
  assign localWr = wrEn && !inUser;

  always_comb begin
    strb           = '0;
    strb.ctrl1We   = localWr && (ofs == OFS_CTRL1);
    strb.ctrl2We   = localWr && (ofs == OFS_CTRL2);
    strb.scratchWe = localWr && (ofs == OFS_SCRATCH);
    strb.rbLoWe    = localWr && (ofs == OFS_RBLO);
    strb.rbHiWe    = localWr && (ofs == OFS_RBHI);
    strb.rdLoad    = rdEn;
  end

  assign dataWrStb = localWr && (ofs == OFS_DATA);
  assign userSel   = inUser && (wrEn || rdEn);
  assign userWe    = inUser && wrEn;
  assign userRe    = inUser && rdEn;

  // falling edge of the readback bit, qualified by finished configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rbStart <= 1'b0;
    else       rbStart <= strb.ctrl1We && rbBitNow && !rbBitNew && cfgDone;
  end
endmodule

// File: rtl/hostRegData.sv
module hostRegData
  import hostreg_pkg::*;
#(
  parameter int          ADDR_W = 5,
  parameter logic [31:0] DEV_ID = 32'h1A2B3C4D
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] userRdData,
  output logic [DATA_W-1:0] rdData,
  output logic              gsrOut,
  output logic              rbReqN,
  output logic              progN,
  output logic [DATA_W-1:0] ctrl2Out,
  output logic [2*DATA_W-1:0] rbAddr
);
  localparam int OFS_W = ADDR_W - 1;

  logic [DATA_W-1:0] scratch, rbLo, rbHi, ctrl1View, readMux;
  logic [DATA_W-1:0] idByte [ID_BYTES];
  logic [1:0]        idSel;
  logic [OFS_W-1:0]  ofs;

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
    assign idByte[g] = DEV_ID[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gsrOut   <= 1'b0;
      rbReqN   <= 1'b1;
      progN    <= 1'b1;
      ctrl2Out <= '0;
      scratch  <= '0;
      rbLo     <= '0;
      rbHi     <= '0;
    end else begin
      if (strb.ctrl1We) begin
        gsrOut <= wrData[GSR_BIT];
        rbReqN <= wrData[RB_BIT];
        progN  <= wrData[PRG_BIT];
      end
      if (strb.ctrl2We)   ctrl2Out <= wrData;
      if (strb.scratchWe) scratch  <= wrData;
      if (strb.rbLoWe)    rbLo     <= wrData;
      if (strb.rbHiWe)    rbHi     <= wrData;
    end
  end

  assign rbAddr = {rbHi, rbLo};
  assign ofs    = addr[OFS_W-1:0];
  assign idSel  = addr[1:0] + 2'd1;   // 7h..Ah -> byte 0..3

  always_comb begin
    ctrl1View          = '0;
    ctrl1View[GSR_BIT] = gsrOut;
    ctrl1View[RB_BIT]  = rbReqN;
    ctrl1View[PRG_BIT] = progN;
  end

  always_comb begin
    readMux = '0;
    if (addr[ADDR_W-1]) readMux = userRdData;
    else if (ofs >= OFS_ID0 && ofs <= OFS_ID3) readMux = idByte[idSel];
    else begin
      case (ofs)
        OFS_CTRL1:   readMux = ctrl1View;
        OFS_CTRL2:   readMux = ctrl2Out;
        OFS_SCRATCH: readMux = scratch;
        OFS_STATUS:  readMux = statusIn;
        OFS_DATA:    readMux = dataIn;
        OFS_RBLO:    readMux = rbLo;
        OFS_RBHI:    readMux = rbHi;
        default:     readMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strb.rdLoad) rdData <= readMux;
  end
endmodule

// File: rtl/hostRegBank.sv
module hostRegBank
  import hostreg_pkg::*;
#(
  parameter int          ADDR_W = 5,
  parameter logic [31:0] DEV_ID = 32'h1A2B3C4D
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [DATA_W-1:0]   statusIn,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic                cfgDone,
  output logic                dataWrStb,
  output logic [DATA_W-1:0]   dataWrByte,
  output logic                gsrOut,
  output logic                rbReqN,
  output logic                rbStart,
  output logic                progN,
  output logic [DATA_W-1:0]   ctrl2Out,
  output logic [2*DATA_W-1:0] rbAddr,
  output logic                userSel,
  output logic                userWe,
  output logic                userRe,
  output logic [ADDR_W-2:0]   userAddr,
  output logic [DATA_W-1:0]   userWrData,
  input  logic [DATA_W-1:0]   userRdData
);
  regStrobes_t strb;

  assign dataWrByte = wrData;
  assign userWrData = wrData;
  assign userAddr   = addr[ADDR_W-2:0];

  hostRegCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .rbBitNew(wrData[RB_BIT]), .rbBitNow(rbReqN), .cfgDone(cfgDone),
    .strb(strb), .rbStart(rbStart), .dataWrStb(dataWrStb),
    .userSel(userSel), .userWe(userWe), .userRe(userRe)
  );

  hostRegData #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrData(wrData),
    .statusIn(statusIn), .dataIn(dataIn), .userRdData(userRdData),
    .rdData(rdData), .gsrOut(gsrOut), .rbReqN(rbReqN), .progN(progN),
    .ctrl2Out(ctrl2Out), .rbAddr(rbAddr)
  );
endmodule

// File: rtl/hostRegChk.sv
module hostRegChk #(
  parameter int          ADDR_W = 5,
  parameter logic [31:0] DEV_ID = 32'h1A2B3C4D
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wrData,
  input logic              cfgDone,
  input logic [7:0]        rdData,
  input logic              gsrOut,
  input logic              progN,
  input logic              rbReqN,
  input logic              rbStart,
  input logic              userSel
);
  logic ctrl1Wr;
  assign ctrl1Wr = wrEn && (addr == '0);

  AST_GSR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl1Wr |=> $stable(gsrOut)); // R3
  AST_PROG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl1Wr |=> $stable(progN)); // R5
  AST_RB_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rbStart |=> !rbStart); // R4
  AST_RB_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    rbStart |-> $past(ctrl1Wr && !wrData[5] && rbReqN && cfgDone)); // R4
  AST_RB_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl1Wr |=> !rbStart); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R11
  AST_USER_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn || rdEn) |-> !userSel); // R10
  AST_ID_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 5'h07) |=> rdData == DEV_ID[7:0]); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 5'h0C) |=> rdData == 8'h00); // R9
endmodule

bind hostRegBank hostRegChk #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .cfgDone(cfgDone), .rdData(rdData), .gsrOut(gsrOut),
  .progN(progN), .rbReqN(rbReqN), .rbStart(rbStart), .userSel(userSel)
);

// File: tb/hostRegBank_tb.sv
module hostRegBank_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID = 32'h1A2B3C4D;

  logic clk = 0, rstN = 0, wrEn = 0, rdEn = 0, cfgDone = 0;
  logic [4:0] addr = 0;
  logic [7:0] wrData = 0, statusIn = 8'h00, dataIn = 8'h00, userRdData = 8'h00;
  logic [7:0] rdData, dataWrByte, ctrl2Out, userWrData;
  logic [15:0] rbAddr;
  logic [3:0] userAddr;
  logic dataWrStb, gsrOut, rbReqN, rbStart, progN, userSel, userWe, userRe;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  string curReq = "R1";

  // behavioural reference state: local bytes indexed by address
  byte unsigned mem[16];
  byte unsigned eRd;
  bit eRbPulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostRegBank #(.DEV_ID(ID)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .statusIn(statusIn), .dataIn(dataIn),
    .cfgDone(cfgDone), .dataWrStb(dataWrStb), .dataWrByte(dataWrByte),
    .gsrOut(gsrOut), .rbReqN(rbReqN), .rbStart(rbStart), .progN(progN),
    .ctrl2Out(ctrl2Out), .rbAddr(rbAddr), .userSel(userSel), .userWe(userWe),
    .userRe(userRe), .userAddr(userAddr), .userWrData(userWrData),
    .userRdData(userRdData)
  );

  task automatic cmp(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic byte unsigned modelRead(logic [4:0] a);
    int ofs = int'(a[3:0]);
    if (a[4]) return userRdData;
    if (ofs == 3) return statusIn;
    if (ofs == 4) return dataIn;
    if (ofs >= 7 && ofs <= 10) return byte'(ID >> (8 * (ofs - 7)));
    return mem[ofs];
  endfunction

  task automatic modelReset();
    foreach (mem[i]) mem[i] = 0;
    mem[0] = 8'hA0;   // program and readback bits idle high
    eRd = 0; eRbPulse = 0;
  endtask

  task automatic compareAll();
    cmp(curReq, "rdData", rdData, eRd);
    cmp("R3", "gsrOut", gsrOut, mem[0][0]);
    cmp("R4", "rbReqN", rbReqN, mem[0][5]);
    cmp("R4", "rbStart", rbStart, eRbPulse);
    cmp("R5", "progN", progN, mem[0][7]);
    cmp("R6", "ctrl2Out", ctrl2Out, mem[1]);
    cmp("R6", "rbAddr", rbAddr, {mem[6], mem[5]});
  endtask

  task automatic busCycle(bit we, bit re, logic [4:0] a, logic [7:0] d);
    bit inUser = a[4];
    wrEn = we; rdEn = re; addr = a; wrData = d;
    #1;
    cmp("R10", "userSel", userSel, inUser && (we || re));
    cmp("R10", "userWe", userWe, inUser && we);
    cmp("R10", "userRe", userRe, inUser && re);
    if (inUser) cmp("R10", "userAddr", userAddr, a[3:0]);
    cmp("R7", "dataWrStb", dataWrStb, we && a == 5'h04);
    if (we && a == 5'h04) cmp("R7", "dataWrByte", dataWrByte, d);
    @(posedge clk);
    eRbPulse = we && a == 5'h00 && mem[0][5] && !d[5] && cfgDone;
    if (re) eRd = modelRead(a);
    if (we && !a[4]) begin
      case (int'(a[3:0]))
        0: mem[0] = d & 8'hA1;
        1, 2, 5, 6: mem[a[3:0]] = d;
        default: ;
      endcase
    end
    @(negedge clk);
    compareAll();
    wrEn = 0; rdEn = 0;
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d); busCycle(1, 0, a, d); endtask
  task automatic rd(logic [4:0] a); busCycle(0, 1, a, 8'h00); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) busCycle(0, 0, 5'h00, 8'h00); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    curReq = "R1"; compareAll();            // R1 reset values
    rstN = 1;
    idle(2);

    curReq = "R2";                           // R2 reserved bits read 0
    wr(5'h00, 8'hFF); rd(5'h00);
    wr(5'h00, 8'h5E); rd(5'h00);
    wr(5'h00, 8'hA0); rd(5'h00);

    curReq = "R6";                           // R6 plain registers
    wr(5'h01, 8'hC3); wr(5'h02, 8'h5A); wr(5'h05, 8'h34); wr(5'h06, 8'h12);
    rd(5'h01); rd(5'h02); rd(5'h05); rd(5'h06);

    curReq = "R3";                           // R3 global reset held until cleared
    wr(5'h00, 8'hA1); idle(4); rd(5'h02);
    curReq = "R5"; rd(5'h01); rd(5'h06);     // R5 registers survive global reset
    curReq = "R3"; wr(5'h00, 8'hA0); idle(2);

    curReq = "R4";                           // R4 readback start rules
    cfgDone = 0; wr(5'h00, 8'h80); idle(1);  // no pulse without done
    wr(5'h00, 8'hA0); cfgDone = 1; idle(1);
    wr(5'h00, 8'h80); idle(2);               // pulse
    wr(5'h00, 8'h80); idle(1);               // already low: no pulse
    wr(5'h00, 8'hA0); wr(5'h02, 8'h00); rd(5'h00);

    curReq = "R5";                           // R5 program request
    wr(5'h00, 8'h20); idle(2); rd(5'h05); rd(5'h01); rd(5'h00);
    wr(5'h00, 8'hA0);

    curReq = "R7";                           // R7 status and data windows
    statusIn = 8'h6B; dataIn = 8'hE4; rd(5'h03); rd(5'h04);
    wr(5'h04, 8'h99); statusIn = 8'h11; rd(5'h03);

    curReq = "R8";                           // R8 identifier bytes
    for (int i = 7; i <= 10; i++) rd(5'(i));
    wr(5'h07, 8'hFF); wr(5'h0A, 8'h00); rd(5'h07); rd(5'h0A);

    curReq = "R9";                           // R9 reserved addresses
    for (int i = 11; i <= 15; i++) begin wr(5'(i), 8'h77); rd(5'(i)); end
    rd(5'h02); rd(5'h00);

    curReq = "R10";                          // R10 user space
    userRdData = 8'h3C; rd(5'h10); userRdData = 8'hD2; rd(5'h1F);
    wr(5'h15, 8'h81); wr(5'h1A, 8'h42); rd(5'h02);

    curReq = "R11";                          // R11 hold and read-before-write
    rd(5'h01); idle(3);
    busCycle(1, 1, 5'h02, 8'hEE); rd(5'h02);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule